// File: doc/BRIEF.md
# Saturating Branch Sample Record Buffer

This block keeps a short history of taken branches for a performance-sampling unit. Once a sampling counter has overflowed while sampling is enabled, each retired taken branch deposits its source and target address into the next slot of a fixed-depth buffer. The fill is a single pass from the current write offset up to the last slot. It never wraps over older data. When the last slot is written, the block disables itself and the offset returns to zero.

The counter-overflow interrupt is not raised when the overflow occurs. It is held back until the buffer has filled, so the handler sees a complete branch history. Software can also release a held interrupt early by clearing the enable bit.

Software reaches the block through one control/status register and a bank of indexed entry registers. The entry registers can be read and written, which allows software to plant a marker value in a slot and recognise stale entries later.

Top module: `brsamp_buf`

## Requirements
- R1: After a synchronous active-high reset, the control register reads 0x0000_0000_0000_0018 (only the fixed bits set), `irq` is 0, every entry register reads 0 and no interrupt is held.
- R2: Control register layout. Bit 2 is sample enable. Bits [4:3] always read 11b. Bit 5 is the valid-branches flag. Bits [19:16] are the next-write offset. Bits [26:24] are the counter select. All other bits read 0. Writing 0xFFFF_FFFF_FFFF_FFFF reads back as 0x0000_0000_070F_003C.
- R3: With `reg_addr[5]`=0, address 2*i selects the source register of entry i and address 2*i+1 selects its target register. `reg_addr`=32 selects the control register. Every entry register stores and returns all 64 written bits, for example 0xFFFF_FFFF_FFFF_FFFE.
- R4: An entry is captured only when all three hold: enable is 1, an overflow arrived in an earlier cycle while enabled (which holds the interrupt), and `br_valid` is 1. A capture stores `br_from`/`br_to` at the current offset, increments the offset and sets the valid flag. At most one entry is captured per cycle, and an overflow in the same cycle as a branch does not capture that branch.
- R5: Capture fills slots from the starting offset up to DEPTH-1 and then stops. The capture into slot DEPTH-1 sets the offset to 0 and clears enable. Later branches change no entry, and slots below the starting offset keep their contents.
- R6: An overflow never pulses `irq` by itself. `irq` is a one-cycle pulse in the cycle after the capture that fills slot DEPTH-1.
- R7: A control write with bit 2 = 0 while an interrupt is held pulses `irq` in the next cycle and drops the held state.
- R8: A control write takes effect in the next cycle. When it coincides with a capture, enable, flag and offset take the written values, and the branch is still stored at the old offset.
- R9: Writing the control register with bit 5 = 0 clears the valid-branches flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Retired taken branch strobe |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch target address |
| ovf | input | 1 | Sampling counter overflow pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register select: bit 5 selects control, else entry register 2*i / 2*i+1 |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Overflow interrupt pulse, released on fill or on enable cleared |

## Verification
The offset and the held-interrupt flag together decide which slot is written, so a wrong internal state surfaces at the ports in one of two ways. It appears either as a misplaced entry in the read data or as an `irq` pulse at the wrong cycle. The bench compares `irq` and the addressed register against a behavioural model after every clock. A wrong offset step is therefore seen in the cycle after the faulty capture, and a late or early release is seen in the exact cycle it happens. The entry bank is swept after each fill to catch overwrites of slots outside the fill window.

// File: rtl/brsamp_pkg.sv
package brsamp_pkg;
    localparam int DATA_W    = 64;
    localparam int OFF_W     = 4;
    localparam int SEL_W     = 3;
    localparam int EN_BIT    = 2;
    localparam int FIX_LSB   = 3;
    localparam int VB_BIT    = 5;
    localparam int OFF_LSB   = 16;
    localparam int SEL_LSB   = 24;

    typedef struct packed {
        logic             en;
        logic             vb;
        logic [OFF_W-1:0] off;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[EN_BIT]             = c.en;
        r[FIX_LSB +: 2]       = 2'b11;
        r[VB_BIT]             = c.vb;
        r[OFF_LSB +: OFF_W]   = c.off;
        r[SEL_LSB +: SEL_W]   = c.sel;
        return r;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en  = w[EN_BIT];
        c.vb  = w[VB_BIT];
        c.off = w[OFF_LSB +: OFF_W];
        c.sel = w[SEL_LSB +: SEL_W];
        return c;
    endfunction
endpackage

// File: rtl/brsamp_ctrl.sv
module brsamp_ctrl
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  br_valid,
    input  logic  ovf,
    input  logic  cw_en,
    input  ctrl_t cw_val,
    output ctrl_t ctrl_q,
    output logic  held_q,
    output logic  cap_fire,
    output logic  irq_q
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(DEPTH - 1);

    logic  at_last;
    logic  fill;
    logic  release_now;
    ctrl_t ctrl_d;

    assign cap_fire    = ctrl_q.en & held_q & br_valid;
    assign at_last     = (ctrl_q.off == LAST);
    assign fill        = cap_fire & at_last;
    assign release_now = held_q & (fill | (cw_en & ~cw_val.en));

    always_comb begin
        ctrl_d = ctrl_q;
        if (cap_fire) begin
            ctrl_d.vb  = 1'b1;
            ctrl_d.off = at_last ? '0 : ctrl_q.off + 1'b1;
            if (at_last) begin
                ctrl_d.en = 1'b0;
            end
        end
        if (cw_en) begin
            ctrl_d = cw_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            held_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            irq_q  <= release_now;
            if (release_now) begin
                held_q <= 1'b0;
            end else if (ovf && ctrl_q.en) begin
                held_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/brsamp_store.sv
module brsamp_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_we,
    input  logic [$clog2(DEPTH)-1:0] cap_idx,
    input  logic [DATA_W-1:0] cap_from,
    input  logic [DATA_W-1:0] cap_to,
    input  logic              sw_we,
    input  logic [$clog2(DEPTH):0] sw_addr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic [$clog2(DEPTH):0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IW = $clog2(DEPTH);

    logic [DATA_W-1:0] from_r [DEPTH];
    logic [DATA_W-1:0] to_r   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic sw_from_hit;
        logic sw_to_hit;
        logic cap_hit;

        assign sw_from_hit = sw_we && (sw_addr == {IW'(i), 1'b0});
        assign sw_to_hit   = sw_we && (sw_addr == {IW'(i), 1'b1});
        assign cap_hit     = cap_we && (cap_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                from_r[i] <= '0;
                to_r[i]   <= '0;
            end else begin
                if (sw_from_hit) begin
                    from_r[i] <= sw_data;
                end else if (cap_hit) begin
                    from_r[i] <= cap_from;
                end
                if (sw_to_hit) begin
                    to_r[i] <= sw_data;
                end else if (cap_hit) begin
                    to_r[i] <= cap_to;
                end
            end
        end
    end

    assign rd_data = rd_addr[0] ? to_r[rd_addr[IW:1]] : from_r[rd_addr[IW:1]];
endmodule

// File: rtl/brsamp_buf.sv
module brsamp_buf
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     br_valid,
    input  logic [DATA_W-1:0]        br_from,
    input  logic [DATA_W-1:0]        br_to,
    input  logic                     ovf,
    input  logic                     reg_wr_en,
    input  logic [$clog2(DEPTH)+1:0] reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     irq
);
    localparam int IW   = $clog2(DEPTH);
    localparam int EA_W = IW + 1;

    ctrl_t             ctrl_q;
    logic              held;
    logic              cap_fire;
    logic              ctl_sel;
    logic              cw_en;
    logic [DATA_W-1:0] ent_rdata;

    assign ctl_sel = reg_addr[EA_W];
    assign cw_en   = reg_wr_en & ctl_sel;

    brsamp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .br_valid (br_valid),
        .ovf      (ovf),
        .cw_en    (cw_en),
        .cw_val   (ctrl_unpack(reg_wdata)),
        .ctrl_q   (ctrl_q),
        .held_q   (held),
        .cap_fire (cap_fire),
        .irq_q    (irq)
    );

    brsamp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cap_we   (cap_fire),
        .cap_idx  (ctrl_q.off[IW-1:0]),
        .cap_from (br_from),
        .cap_to   (br_to),
        .sw_we    (reg_wr_en & ~ctl_sel),
        .sw_addr  (reg_addr[EA_W-1:0]),
        .sw_data  (reg_wdata),
        .rd_addr  (reg_addr[EA_W-1:0]),
        .rd_data  (ent_rdata)
    );

    assign reg_rdata = ctl_sel ? ctrl_pack(ctrl_q) : ent_rdata;
endmodule

// File: rtl/brsamp_buf_chk.sv
module brsamp_buf_chk
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             br_valid,
    input logic             cw,
    input logic             cw_en_bit,
    input logic             en,
    input logic [OFF_W-1:0] off,
    input logic             held,
    input logic             irq,
    input logic             ctl_sel,
    input logic [1:0]       fixed_bits
);
    logic go;
    assign go = en && held && br_valid;

    // R4: a capture without a control write steps the offset by one
    a_r4_offset_step: assert property (@(posedge clk) disable iff (rst)
        (go && !cw && off != OFF_W'(DEPTH-1)) |=> (off == $past(off) + 1'b1));

    // R4: no capture and no write leaves the offset unchanged
    a_r4_offset_idle: assert property (@(posedge clk) disable iff (rst)
        (!go && !cw) |=> $stable(off));

    // R5: filling the last slot stops capture and wraps the offset
    a_r5_fill_stops: assert property (@(posedge clk) disable iff (rst)
        (go && !cw && off == OFF_W'(DEPTH-1)) |=> (!en && off == '0));

    // R6: filling the last slot releases the held interrupt
    a_r6_irq_on_fill: assert property (@(posedge clk) disable iff (rst)
        (go && off == OFF_W'(DEPTH-1)) |=> irq);

    // R6: an interrupt pulse always comes from a held state
    a_r6_irq_from_held: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(held));

    // R7: clearing enable while held releases the interrupt
    a_r7_release_on_clear: assert property (@(posedge clk) disable iff (rst)
        (held && cw && !cw_en_bit) |=> irq);

    // R2: fixed bits of the control register read as ones
    a_r2_fixed_ones: assert property (@(posedge clk) disable iff (rst)
        ctl_sel |-> (fixed_bits == 2'b11));
endmodule

bind brsamp_buf brsamp_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .br_valid   (br_valid),
    .cw         (cw_en),
    .cw_en_bit  (reg_wdata[2]),
    .en         (ctrl_q.en),
    .off        (ctrl_q.off),
    .held       (held),
    .irq        (irq),
    .ctl_sel    (ctl_sel),
    .fixed_bits (reg_rdata[4:3])
);

// File: tb/brsamp_buf_bench.sv
`timescale 1ns/1ps
module brsamp_buf_bench;
    localparam int D = 16;
    localparam int CTL = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [63:0] br_from = '0;
    logic [63:0] br_to = '0;
    logic        ovf = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = 6'(CTL);
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    brsamp_buf u_brsamp_buf (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .ovf(ovf), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model
    bit          m_en, m_vb, m_held, m_irq;
    int          m_off, m_sel;
    logic [63:0] m_from [D];
    logic [63:0] m_to   [D];

    function automatic logic [63:0] m_read(int a);
        if (a >= CTL)
            return 64'(m_en) * 4 + 64'h18 + 64'(m_vb) * 32 + 64'(m_off) * 65536 + 64'(m_sel) * 16777216;
        else if (a % 2 == 1) return m_to[a/2];
        else return m_from[a/2];
    endfunction

    task automatic m_reset();
        m_en = 0; m_vb = 0; m_held = 0; m_irq = 0; m_off = 0; m_sel = 0;
        for (int i = 0; i < D; i++) begin m_from[i] = '0; m_to[i] = '0; end
    endtask

    task automatic m_step(bit bv, logic [63:0] f, logic [63:0] t, bit ov, bit wr, int a, logic [63:0] wd);
        bit fire, fill, rel, old_en;
        fire = m_en && m_held && bv;
        fill = fire && (m_off == D-1);
        rel = m_held && (fill || (wr && a >= CTL && wd[2] == 1'b0));
        old_en = m_en;
        if (fire && !(wr && a < CTL && a/2 == m_off)) begin
            m_from[m_off] = f; m_to[m_off] = t;
        end
        if (wr && a < CTL) begin
            if (a % 2 == 1) m_to[a/2] = wd; else m_from[a/2] = wd;
        end
        if (fire) begin
            m_vb = 1;
            if (m_off == D-1) begin m_off = 0; m_en = 0; end
            else m_off = m_off + 1;
        end
        if (wr && a >= CTL) begin
            m_en = wd[2]; m_vb = wd[5]; m_off = int'(wd[19:16]); m_sel = int'(wd[26:24]);
        end
        if (rel) m_held = 0;
        else if (ov && old_en) m_held = 1;
        m_irq = rel;
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive, model, compare irq and addressed register
    task automatic cyc(string req, bit bv, logic [63:0] f, logic [63:0] t, bit ov, bit wr, int a, logic [63:0] wd);
        @(negedge clk);
        br_valid = bv; br_from = f; br_to = t; ovf = ov;
        reg_wr_en = wr; reg_addr = 6'(a); reg_wdata = wd;
        @(posedge clk);
        m_step(bv, f, t, ov, wr, a, wd);
        #1;
        check({req, " irq"}, 64'(irq), 64'(m_irq));
        check({req, " rdata"}, reg_rdata, m_read(a));
    endtask

    task automatic rd(string req, int a);
        cyc(req, 0, 0, 0, 0, 0, a, 0);
    endtask

    task automatic wr_ctl(string req, logic [63:0] v);
        cyc(req, 0, 0, 0, 0, 1, CTL, v);
    endtask

    task automatic br(string req, int k);
        cyc(req, 1, 64'h1000 + 64'(k), 64'h2000_0000 + 64'(k), 0, 0, CTL, 0);
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < 2*D; a++) rd(req, a);
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1: reset state
        check("R1 ctrl", reg_rdata, 64'h18);
        check("R1 irq", 64'(irq), 64'h0);
        rd("R1 entry", 0);

        // R2: layout and read-only fixed bits
        wr_ctl("R2 all-ones", 64'hFFFF_FFFF_FFFF_FFFF);
        check("R2 value", reg_rdata, 64'h0000_0000_070F_003C);
        // R9: flag cleared by writing 0
        wr_ctl("R9 clear", 64'h0);
        check("R9 value", reg_rdata, 64'h18);

        // R3: entry addressing and full-width readback
        cyc("R3 poison", 0, 0, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc("R3 from3", 0, 0, 0, 0, 1, 6, 64'hDEAD_BEEF_0123_4567);
        rd("R3 rd1", 1); rd("R3 rd6", 6); rd("R3 rd7", 7); rd("R3 rd0", 0);

        // R4: no capture without prior overflow
        wr_ctl("R4 enable", 64'h4);
        for (int k = 0; k < 3; k++) br("R4 no-ovf", 100 + k);
        // R4/R6: overflow with branch same cycle does not capture, no irq
        cyc("R6 ovf", 1, 64'h77, 64'h88, 1, 0, CTL, 0);
        check("R4 off after ovf", reg_rdata, 64'h1C);
        // R4/R5/R6: fill 16 slots back to back
        for (int k = 0; k < D; k++) br("R5 fill", k);
        check("R6 irq at fill", 64'(irq), 64'h1);
        check("R5 ctrl after fill", reg_rdata, 64'h38);
        for (int k = 0; k < 3; k++) br("R5 stopped", 200 + k);
        sweep("R5 sweep");

        // R5: partial fill from offset 12 keeps lower slots
        for (int a = 0; a < 2*D; a++) cyc("R3 mark", 0, 0, 0, 0, 1, a, 64'h5A00 + 64'(a));
        wr_ctl("R5 start12", 64'h000C_0004);
        cyc("R6 ovf2", 0, 0, 0, 1, 0, CTL, 0);
        for (int k = 0; k < 4; k++) br("R5 partial", 300 + k);
        check("R6 irq partial", 64'(irq), 64'h1);
        sweep("R5 sweep2");

        // R7: early release by clearing enable
        wr_ctl("R7 enable", 64'h4);
        cyc("R7 ovf", 0, 0, 0, 1, 0, CTL, 0);
        br("R7 br", 400); br("R7 br", 401);
        wr_ctl("R7 clear", 64'h0);
        check("R7 irq", 64'(irq), 64'h1);
        br("R7 after", 402);

        // R8: control write racing a capture
        wr_ctl("R8 start5", 64'h0005_0004);
        cyc("R8 ovf", 0, 0, 0, 1, 0, CTL, 0);
        cyc("R8 race", 1, 64'hAAAA, 64'hBBBB, 0, 1, CTL, 64'h0009_0004);
        check("R8 ctrl", reg_rdata, 64'h0009_001C);
        rd("R8 slot5from", 10); rd("R8 slot5to", 11);
        br("R8 next", 500);
        rd("R8 slot9", 18);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual %h expected %h", 64'h0, 64'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule